// File: doc/BRIEF.md
# Real-Time Clock Time Counter

This block keeps time for a real-time clock. A prescaler counter advances once for each single-cycle `tick_i` pulse. When the lower fifteen prescaler bits carry out, the seconds counter steps. With a 32.768 kHz tick, that gives one second per 32768 ticks.

An alarm compare register raises a flag when the seconds counter steps away from the alarm value. A status word holds four things: the counting enable, the alarm flag, the overflow flag and the invalid flag.

Software reaches all of this over a word-wide register port. Each access is one cycle, and read data is registered. The counters accept writes only while counting is switched off. They read as zero while time is invalid or has overflowed. The invalid flag comes up on reset. Software must load a fresh seconds value before counting can resume.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, the status word reads 0x0000_0001 (invalid flag set, counting off). The seconds, prescaler and alarm registers read 0.
- R2: The status word at offset 0x14 places the enable at bit 4, the alarm flag at bit 2, the overflow flag at bit 1 and the invalid flag at bit 0. All other bits read 0. Only bit 4 is writable, so writing 0xFFFF_FFFF after reset reads back as 0x11.
- R3: While the enable is 0, writes to seconds (offset 0x00) and prescaler (offset 0x04) take effect, and ticks change neither register.
- R4: While the enable is 1 and no flag blocks counting, each tick adds 1 to the prescaler. Seconds add 1 on the tick that takes the prescaler's low 15 bits from all ones to zero. Writes to seconds and prescaler are ignored.
- R5: The alarm flag sets when seconds step while the alarm register (offset 0x08) equals the seconds value held before the step. A step with a different alarm value leaves the flag clear.
- R6: Any write to the alarm register clears the alarm flag. If a set and a clear fall in the same cycle, the clear wins.
- R7: The overflow flag sets when seconds step from all ones while counting is enabled.
- R8: While the overflow or invalid flag is set, seconds and prescaler hold their values and read as 0, and no alarm match is evaluated.
- R9: A seconds write made while the enable is 0 clears both the overflow and invalid flags. A seconds write made while the enable is 1 clears neither.
- R10: Read data appears on `rdata_o` one cycle after the address is presented. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle time base pulse |
| addr_i | input | ADDR_W (8) | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data for the address of the previous cycle |

## Verification
The in-line assertions check five cycle-level rules on every clock:
- the prescaler steps by one on each enabled tick and holds otherwise;
- the alarm flag sets on a matching step and clears after an alarm write;
- the overflow flag follows a wrap;
- both blocking flags drop after a seconds write made while counting is off;
- a seconds read returns zero while either blocking flag is set.

Other properties need a specific setup and only the bench's scenarios show them. These are:
- the reset value and bit layout of the status word;
- that the held counter values survive a blocked period and become visible again once the flag clears;
- that writes made while enabled really leave the counters unchanged;
- that an alarm equal to the seconds value stays silent while time is invalid.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_SEC   = 8'h00;
  localparam logic [7:0] OFF_PRE   = 8'h04;
  localparam logic [7:0] OFF_ALARM = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h14;

  // status word bit positions
  localparam int unsigned ST_INVALID  = 0;
  localparam int unsigned ST_OVERFLOW = 1;
  localparam int unsigned ST_ALARM    = 2;
  localparam int unsigned ST_ENABLE   = 4;

  typedef struct packed {
    logic enable;
    logic alarm;
    logic overflow;
    logic invalid;
  } rtc_flags_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned TAP    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              sec_we_i,
  input  logic              pre_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SEC_W-1:0]  sec_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic              sec_step_o,
  output logic              sec_wrap_o
);
  logic adv;

  assign adv        = run_i & tick_i;
  assign sec_step_o = adv & (&pre_q[TAP-1:0]);
  assign sec_wrap_o = sec_step_o & (&sec_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (pre_we_i) begin
      pre_q <= wdata_i[PRE_W-1:0];
    end else if (adv) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
    end else if (sec_we_i) begin
      sec_q <= wdata_i[SEC_W-1:0];
    end else if (sec_step_o) begin
      sec_q <= sec_q + 1'b1;
    end
  end

  // R4: an enabled tick advances the prescaler by exactly one
  p_pre_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && !pre_we_i) |=> (pre_q == $past(pre_q) + 1'b1));

  // R3: without a write and without counting, seconds hold
  p_sec_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !sec_we_i) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sec_step_i,
  input  logic [SEC_W-1:0]  sec_q_i,
  output logic [SEC_W-1:0]  alarm_q,
  output logic              taf_q
);
  logic hit;

  assign hit = sec_step_i & (alarm_q == sec_q_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
    end else if (alarm_we_i) begin
      alarm_q <= wdata_i[SEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taf_q <= 1'b0;
    end else if (alarm_we_i) begin
      taf_q <= 1'b0;
    end else if (hit) begin
      taf_q <= 1'b1;
    end
  end

  // R5: a step leaving the alarm value raises the flag
  p_taf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (sec_step_i && !alarm_we_i && (alarm_q == sec_q_i)) |=> taf_q);

  // R6: any alarm write leaves the flag clear
  p_taf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    alarm_we_i |=> !taf_q);
endmodule

// File: rtl/rtc_status.sv
module rtc_status (
  input  logic clk,
  input  logic rst,
  input  logic stat_we_i,
  input  logic en_bit_i,
  input  logic sec_clr_i,
  input  logic wrap_i,
  output logic tce_q,
  output logic tof_q,
  output logic tif_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tce_q <= 1'b0;
    end else if (stat_we_i) begin
      tce_q <= en_bit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tof_q <= 1'b0;
      tif_q <= 1'b1;
    end else begin
      if (sec_clr_i) begin
        tof_q <= 1'b0;
        tif_q <= 1'b0;
      end else if (wrap_i) begin
        tof_q <= 1'b1;
      end
    end
  end

  // R7: a wrap of the seconds counter raises overflow
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> tof_q);

  // R9: a seconds write while disabled drops both blocking flags
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sec_clr_i |=> (!tof_q && !tif_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned TAP    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFF_SEC);
  localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(OFF_PRE);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFF_ALARM);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  rtc_flags_t       flags;
  logic             tce, tof, tif, taf;
  logic             run, blocked;
  logic             sec_we, pre_we, alarm_we, stat_we;
  logic             sec_step, sec_wrap;
  logic [SEC_W-1:0] sec_q, alarm_q;
  logic [PRE_W-1:0] pre_q;
  logic [DATA_W-1:0] rd_word;

  assign blocked  = tof | tif;
  assign run      = tce & ~blocked;
  assign sec_we   = wr_en_i & (addr_i == A_SEC) & ~tce;
  assign pre_we   = wr_en_i & (addr_i == A_PRE) & ~tce;
  assign alarm_we = wr_en_i & (addr_i == A_ALARM);
  assign stat_we  = wr_en_i & (addr_i == A_STAT);

  rtc_counter #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .PRE_W(PRE_W), .TAP(TAP)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .run_i      (run),
    .sec_we_i   (sec_we),
    .pre_we_i   (pre_we),
    .wdata_i    (wdata_i),
    .sec_q      (sec_q),
    .pre_q      (pre_q),
    .sec_step_o (sec_step),
    .sec_wrap_o (sec_wrap)
  );

  rtc_alarm #(
    .DATA_W(DATA_W), .SEC_W(SEC_W)
  ) u_alm (
    .clk        (clk),
    .rst        (rst),
    .alarm_we_i (alarm_we),
    .wdata_i    (wdata_i),
    .sec_step_i (sec_step),
    .sec_q_i    (sec_q),
    .alarm_q    (alarm_q),
    .taf_q      (taf)
  );

  rtc_status u_st (
    .clk       (clk),
    .rst       (rst),
    .stat_we_i (stat_we),
    .en_bit_i  (wdata_i[ST_ENABLE]),
    .sec_clr_i (sec_we),
    .wrap_i    (sec_wrap),
    .tce_q     (tce),
    .tof_q     (tof),
    .tif_q     (tif)
  );

  assign flags = '{enable: tce, alarm: taf, overflow: tof, invalid: tif};

  always_comb begin
    rd_word = '0;
    case (addr_i)
      A_SEC:   if (!blocked) rd_word[SEC_W-1:0] = sec_q;
      A_PRE:   if (!blocked) rd_word[PRE_W-1:0] = pre_q;
      A_ALARM: rd_word[SEC_W-1:0] = alarm_q;
      A_STAT: begin
        rd_word[ST_ENABLE]   = flags.enable;
        rd_word[ST_ALARM]    = flags.alarm;
        rd_word[ST_OVERFLOW] = flags.overflow;
        rd_word[ST_INVALID]  = flags.invalid;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_word;
  end

  // R8: seconds read as zero while a blocking flag is set
  p_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ((tof || tif) && (addr_i == A_SEC)) |=> (rdata_o == '0));
endmodule

// File: tb/sim_rtc_timekeeper.sv
`timescale 1ns/1ps
module sim_rtc_timekeeper;
  localparam logic [7:0] A_SEC = 8'h00, A_PRE = 8'h04, A_ALM = 8'h08,
                         A_STAT = 8'h14, A_GAP = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_timekeeper u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; wr = 1'b0;
    @(negedge clk); chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(A_STAT, 32'h1, "R1 status");
    rd_chk(A_SEC,  32'h0, "R1 seconds");
    rd_chk(A_PRE,  32'h0, "R1 prescaler");
    rd_chk(A_ALM,  32'h0, "R1 alarm");
    rd_chk(A_GAP,  32'h0, "R10 unmapped");
  endtask

  // invalid flag blocks counting and alarm evaluation; values held
  task automatic t_invalid_hold();
    wr_reg(A_PRE, 32'h7FFF);
    wr_reg(A_STAT, 32'h10);
    ticks(3);
    rd_chk(A_STAT, 32'h11, "R8 no alarm while invalid");
    rd_chk(A_PRE, 32'h0, "R8 prescaler reads zero");
    wr_reg(A_STAT, 32'h0);
    wr_reg(A_SEC, 32'h0);
    rd_chk(A_STAT, 32'h0, "R9 invalid cleared");
    rd_chk(A_PRE, 32'h7FFF, "R8 prescaler held");
  endtask

  task automatic t_status_bits();
    wr_reg(A_STAT, 32'hFFFF_FFFF);
    rd_chk(A_STAT, 32'h10, "R2 only enable writable");
    wr_reg(A_STAT, 32'h0);
    rd_chk(A_STAT, 32'h0, "R2 enable cleared");
  endtask

  task automatic t_disabled();
    wr_reg(A_SEC, 32'h100);
    wr_reg(A_PRE, 32'h1234);
    ticks(10);
    rd_chk(A_SEC, 32'h100, "R3 seconds written and held");
    rd_chk(A_PRE, 32'h1234, "R3 prescaler written and held");
  endtask

  task automatic t_counting();
    wr_reg(A_SEC, 32'd5);
    wr_reg(A_PRE, 32'h7FFD);
    wr_reg(A_STAT, 32'h10);
    ticks(2);
    rd_chk(A_PRE, 32'h7FFF, "R4 prescaler steps");
    rd_chk(A_SEC, 32'd5, "R4 no carry yet");
    ticks(1);
    rd_chk(A_PRE, 32'h8000, "R4 prescaler carry");
    rd_chk(A_SEC, 32'd6, "R4 seconds step");
    wr_reg(A_SEC, 32'd99);
    wr_reg(A_PRE, 32'h0042);
    rd_chk(A_SEC, 32'd6, "R4 seconds write ignored");
    rd_chk(A_PRE, 32'h8000, "R4 prescaler write ignored");
    wr_reg(A_STAT, 32'h0);
  endtask

  task automatic t_alarm();
    wr_reg(A_SEC, 32'd20);
    wr_reg(A_PRE, 32'h7FFF);
    wr_reg(A_ALM, 32'd20);
    wr_reg(A_STAT, 32'h10);
    ticks(1);
    rd_chk(A_SEC, 32'd21, "R5 step");
    rd_chk(A_STAT, 32'h14, "R5 alarm set");
    wr_reg(A_ALM, 32'd30);
    rd_chk(A_STAT, 32'h10, "R6 alarm cleared");
    wr_reg(A_STAT, 32'h0);
    wr_reg(A_PRE, 32'h7FFF);
    wr_reg(A_STAT, 32'h10);
    ticks(1);
    rd_chk(A_SEC, 32'd22, "R5 second step");
    rd_chk(A_STAT, 32'h10, "R5 mismatch silent");
    wr_reg(A_STAT, 32'h0);
  endtask

  task automatic t_overflow();
    wr_reg(A_SEC, 32'hFFFF_FFFF);
    wr_reg(A_PRE, 32'h7FFF);
    wr_reg(A_ALM, 32'd0);
    wr_reg(A_STAT, 32'h10);
    ticks(1);
    rd_chk(A_STAT, 32'h12, "R7 overflow set");
    rd_chk(A_SEC, 32'h0, "R8 seconds read zero");
    ticks(5);
    wr_reg(A_SEC, 32'd3);
    rd_chk(A_STAT, 32'h12, "R9 enabled write keeps flag");
    wr_reg(A_STAT, 32'h0);
    wr_reg(A_PRE, 32'h10);
    wr_reg(A_SEC, 32'd7);
    rd_chk(A_STAT, 32'h0, "R9 overflow cleared");
    rd_chk(A_SEC, 32'd7, "R9 seconds loaded");
    rd_chk(A_PRE, 32'h10, "R3 prescaler loaded while flagged");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_invalid_hold();
    t_status_bits();
    t_disabled();
    t_counting();
    t_alarm();
    t_overflow();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule